// File: doc/BRIEF.md
# Trap Entry and Fault Capture Unit

This block sits next to a simple in-order core and performs the control transfer when an exception is raised. The core presents one fault request carrying a 4-bit fault kind and its context: the current PC, the faulting virtual address, the instruction word, six access flag bits, a privileged-mode bit and three qualifiers (speculative access, page-table-entry load, no-fault access). The unit maps the kind to a fixed vector offset and adds it to a software-programmed vector base. It updates the exception-return register and fills the data-side or instruction-side fault capture registers. It then returns the redirect target PC and the following PC.

The request and the redirect response are valid/ready streams. At most one response is held. A request is taken only when the response slot is empty or is being drained in the same cycle, so `flt_ready = !rdr_valid || rdr_ready`. While `rdr_ready` is low, a pending response holds all of its fields unchanged, and no new request is taken.

Software reaches the nine privileged registers through a plain register port. Reads are combinational, and writes take effect at the clock edge. Arithmetic traps are not supported. Such a request is answered with an error flag and no redirect, and it updates no register.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset all nine privileged registers read 0, `rdr_valid` is 0 and `flt_ready` is 1.
- R2: The vector offset for each kind code is: 0 reset 0x0001, 1 interrupt 0x0101, 2 machine check 0x0401, 3 alignment 0x0301, 4 data miss single 0x0201, 5 data miss double 0x0281, 6 data page fault 0x0381, 7 data access violation 0x0381, 8 instruction miss 0x0181, 9 instruction page fault 0x0181, 10 instruction access violation 0x0081, 11 unimplemented opcode 0x0481, 12 float disabled 0x0581, 13 privileged call 0x2001, 14 integer overflow 0x0501, 15 arithmetic 0x0501.
- R3: For a supported kind, the response arrives on the clock edge that accepts the request. It carries `rdr_pc` = vector base (index 0) + offset, `rdr_npc` = `rdr_pc` + 4 and `rdr_err` = 0.
- R4: The exception-return register (index 3) is loaded with the request PC when the kind is 0 or 2, or when `flt_priv` is 0. In all other cases it keeps its value.
- R5: For kinds 13 and 14, the exception-return register is increased by 4 after the step of R4.
- R6: For data kinds 3 to 7, when `flt_spec`, `flt_pte_load` and `flt_no_fault` are all 0, the fault VA register (index 4) takes `flt_va`. Otherwise indices 4, 5 and 6 are unchanged.
- R7: In the capture case of R6, the status register (index 5) is set to: instruction bits 31:26 in bits 16:11, instruction bits 25:21 in bits 10:6, `flt_flags` in bits 5:0, and zero above bit 16.
- R8: In the capture case of R6, the data formatted VA register (index 6) becomes the data table base (index 1) OR (`flt_va` >> 13) << 3.
- R9: For instruction kinds 8 to 10 with `flt_spec` = 0, the instruction tag register (index 7) takes the PC. The instruction formatted VA register (index 8) becomes the instruction table base (index 2) OR (PC >> 13) << 3. With `flt_spec` = 1 both are unchanged. `flt_pte_load` and `flt_no_fault` have no effect here.
- R10: Kind 15 gives a response with `rdr_err` = 1, `rdr_pc` = request PC and `rdr_npc` = request PC + 4, and it changes no register.
- R11: `flt_ready` = !`rdr_valid` || `rdr_ready`. A response that is held with `rdr_ready` low keeps `rdr_valid`, `rdr_pc`, `rdr_npc` and `rdr_err` stable.
- R12: Register indices are 0 vector base, 1 data table base, 2 instruction table base, 3 exception return, 4 fault VA, 5 status, 6 data formatted VA, 7 instruction tag, 8 instruction formatted VA. Writes to 0..3 take effect at the clock edge. Writes to 4..8 are ignored. Reads of indices above 8 return 0. A hardware capture takes priority over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault request valid |
| flt_ready | output | 1 | Fault request can be taken |
| flt_kind | input | 4 | Fault kind code |
| flt_pc | input | 64 | PC of the faulting instruction |
| flt_va | input | 64 | Faulting data virtual address |
| flt_inst | input | 32 | Faulting instruction word |
| flt_flags | input | 6 | Access flags for the status register |
| flt_priv | input | 1 | Core is in privileged mode |
| flt_spec | input | 1 | Access is speculative |
| flt_pte_load | input | 1 | Access is a page-table-entry load |
| flt_no_fault | input | 1 | Access is marked no-fault |
| rdr_valid | output | 1 | Redirect response valid |
| rdr_ready | input | 1 | Redirect response taken |
| rdr_pc | output | 64 | New PC |
| rdr_npc | output | 64 | New next PC |
| rdr_err | output | 1 | Unsupported fault kind (no redirect) |
| reg_we | input | 1 | Register port write enable |
| reg_idx | input | 4 | Register port index |
| reg_wdata | input | 64 | Register port write data |
| reg_rdata | output | 64 | Register port read data (combinational) |

## Verification
Every result of an accepted request is due one clock edge after `flt_valid` and `flt_ready` meet. The response fields and all register captures appear at that same edge, and a register port read shows the new value without a further cycle. The bench drives each request on a falling edge and removes it on the next falling edge. It then checks the response and reads back all nine registers in that low phase, before the response is drained at the following rising edge. For the stall case, the bench samples the held response on several consecutive falling edges, and it checks that the queued request appears only on the falling edge after `rdr_ready` rises.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [3:0] {
    FK_RESET   = 4'd0,
    FK_INTR    = 4'd1,
    FK_MCHK    = 4'd2,
    FK_ALIGN   = 4'd3,
    FK_DMISS1  = 4'd4,
    FK_DMISS2  = 4'd5,
    FK_DPAGE   = 4'd6,
    FK_DACV    = 4'd7,
    FK_IMISS   = 4'd8,
    FK_IPAGE   = 4'd9,
    FK_IACV    = 4'd10,
    FK_OPDEC   = 4'd11,
    FK_FEN     = 4'd12,
    FK_PALCALL = 4'd13,
    FK_OVF     = 4'd14,
    FK_ARITH   = 4'd15
  } fault_kind_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_DATA  = 2'd1,
    FC_INSTR = 2'd2
  } fault_cls_e;

  localparam int VEC_W = 16;

  typedef struct packed {
    logic [VEC_W-1:0] offset;
    logic             force_restart;
    logic             skip_inst;
    logic             unsupported;
    fault_cls_e       cls;
  } vec_info_t;

  localparam int NUM_PREGS       = 9;
  localparam int PIDX_W          = 4;
  localparam int NUM_SW_WRITABLE = 4;

  localparam logic [PIDX_W-1:0] PR_VBASE = 4'd0;
  localparam logic [PIDX_W-1:0] PR_DPTB  = 4'd1;
  localparam logic [PIDX_W-1:0] PR_IPTB  = 4'd2;
  localparam logic [PIDX_W-1:0] PR_EXC   = 4'd3;
  localparam logic [PIDX_W-1:0] PR_FVA   = 4'd4;
  localparam logic [PIDX_W-1:0] PR_MMST  = 4'd5;
  localparam logic [PIDX_W-1:0] PR_DFVA  = 4'd6;
  localparam logic [PIDX_W-1:0] PR_ITAG  = 4'd7;
  localparam logic [PIDX_W-1:0] PR_IFVA  = 4'd8;

endpackage

// File: rtl/trap_vector_map.sv
module trap_vector_map
  import trap_pkg::*;
(
  input  fault_kind_e kind,
  output vec_info_t   info
);

  always_comb begin
    info               = '0;
    info.cls           = FC_NONE;
    info.force_restart = (kind == FK_RESET) || (kind == FK_MCHK);
    info.skip_inst     = (kind == FK_PALCALL) || (kind == FK_OVF);
    info.unsupported   = (kind == FK_ARITH);
    unique case (kind)
      FK_RESET:   info.offset = 16'h0001;
      FK_INTR:    info.offset = 16'h0101;
      FK_MCHK:    info.offset = 16'h0401;
      FK_ALIGN:   begin info.offset = 16'h0301; info.cls = FC_DATA;  end
      FK_DMISS1:  begin info.offset = 16'h0201; info.cls = FC_DATA;  end
      FK_DMISS2:  begin info.offset = 16'h0281; info.cls = FC_DATA;  end
      FK_DPAGE:   begin info.offset = 16'h0381; info.cls = FC_DATA;  end
      FK_DACV:    begin info.offset = 16'h0381; info.cls = FC_DATA;  end
      FK_IMISS:   begin info.offset = 16'h0181; info.cls = FC_INSTR; end
      FK_IPAGE:   begin info.offset = 16'h0181; info.cls = FC_INSTR; end
      FK_IACV:    begin info.offset = 16'h0081; info.cls = FC_INSTR; end
      FK_OPDEC:   info.offset = 16'h0481;
      FK_FEN:     info.offset = 16'h0581;
      FK_PALCALL: info.offset = 16'h2001;
      FK_OVF:     info.offset = 16'h0501;
      FK_ARITH:   info.offset = 16'h0501;
      default:    info.offset = 16'h0001;
    endcase
  end

endmodule

// File: rtl/trap_va_format.sv
module trap_va_format #(
  parameter int XLEN      = 64,
  parameter int PAGE_BITS = 13,
  parameter int PTE_SHIFT = 3
) (
  input  logic [XLEN-1:0] table_base,
  input  logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] formatted
);

  logic [XLEN-1:0] page_num;
  logic [PAGE_BITS-1:0] unused_offset;

  assign page_num      = {{PAGE_BITS{1'b0}}, addr[XLEN-1:PAGE_BITS]};
  assign unused_offset = addr[PAGE_BITS-1:0];
  assign formatted     = table_base | (page_num << PTE_SHIFT);

endmodule

// File: rtl/trap_fault_capture.sv
module trap_fault_capture
  import trap_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int PAGE_BITS = 13,
  parameter int INST_W    = 32,
  parameter int FLAG_W    = 6
) (
  input  logic              take,
  input  fault_cls_e        cls,
  input  logic              spec,
  input  logic              pte_load,
  input  logic              no_fault,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   va,
  input  logic [INST_W-1:0] inst,
  input  logic [FLAG_W-1:0] flags,
  input  logic [XLEN-1:0]   data_tbase,
  input  logic [XLEN-1:0]   inst_tbase,
  output logic              dcap_en,
  output logic              icap_en,
  output logic [XLEN-1:0]   status_val,
  output logic [XLEN-1:0]   dfmt_val,
  output logic [XLEN-1:0]   ifmt_val
);

  localparam int OPC_W  = 6;
  localparam int RA_W   = 5;
  localparam int STAT_W = OPC_W + RA_W + FLAG_W;
  localparam int NSIDE  = 2;

  logic [OPC_W-1:0] opcode;
  logic [RA_W-1:0]  ra_field;
  logic [INST_W-OPC_W-RA_W-1:0] unused_inst;

  assign opcode      = inst[INST_W-1 -: OPC_W];
  assign ra_field    = inst[INST_W-OPC_W-1 -: RA_W];
  assign unused_inst = inst[INST_W-OPC_W-RA_W-1:0];

  assign dcap_en = take && (cls == FC_DATA) && !spec && !pte_load && !no_fault;
  assign icap_en = take && (cls == FC_INSTR) && !spec;

  assign status_val = {{(XLEN-STAT_W){1'b0}}, opcode, ra_field, flags};

  logic [NSIDE-1:0][XLEN-1:0] side_base;
  logic [NSIDE-1:0][XLEN-1:0] side_addr;
  logic [NSIDE-1:0][XLEN-1:0] side_fmt;

  assign side_base[0] = data_tbase;
  assign side_addr[0] = va;
  assign side_base[1] = inst_tbase;
  assign side_addr[1] = pc;

  for (genvar g = 0; g < NSIDE; g++) begin : g_fmt
    trap_va_format #(
      .XLEN      (XLEN),
      .PAGE_BITS (PAGE_BITS),
      .PTE_SHIFT (3)
    ) u_fmt (
      .table_base (side_base[g]),
      .addr       (side_addr[g]),
      .formatted  (side_fmt[g])
    );
  end

  assign dfmt_val = side_fmt[0];
  assign ifmt_val = side_fmt[1];

endmodule

// File: rtl/trap_priv_regs.sv
module trap_priv_regs
  import trap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sw_we,
  input  logic [PIDX_W-1:0]                sw_idx,
  input  logic [XLEN-1:0]                  sw_wdata,
  input  logic [NUM_PREGS-1:0]             hw_we,
  input  logic [NUM_PREGS-1:0][XLEN-1:0]   hw_d,
  output logic [NUM_PREGS-1:0][XLEN-1:0]   regs_o
);

  for (genvar i = 0; i < NUM_PREGS; i++) begin : g_reg
    localparam bit SW_OK = (i < NUM_SW_WRITABLE);
    logic sw_hit;
    assign sw_hit = SW_OK && sw_we && (sw_idx == PIDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_o[i] <= '0;
      else if (hw_we[i])  regs_o[i] <= hw_d[i];
      else if (sw_hit)    regs_o[i] <= sw_wdata;
    end

    if (!SW_OK) begin : g_ro_chk
      assert_ro_reg_hold_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        !hw_we[i] |=> $stable(regs_o[i]));
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int PAGE_BITS = 13,
  parameter int INST_W    = 32,
  parameter int FLAG_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  output logic              flt_ready,
  input  logic [3:0]        flt_kind,
  input  logic [XLEN-1:0]   flt_pc,
  input  logic [XLEN-1:0]   flt_va,
  input  logic [INST_W-1:0] flt_inst,
  input  logic [FLAG_W-1:0] flt_flags,
  input  logic              flt_priv,
  input  logic              flt_spec,
  input  logic              flt_pte_load,
  input  logic              flt_no_fault,
  output logic              rdr_valid,
  input  logic              rdr_ready,
  output logic [XLEN-1:0]   rdr_pc,
  output logic [XLEN-1:0]   rdr_npc,
  output logic              rdr_err,
  input  logic              reg_we,
  input  logic [3:0]        reg_idx,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata
);

  localparam logic [XLEN-1:0] INST_BYTES = XLEN'(4);

  fault_kind_e kind;
  vec_info_t   info;
  logic        accept;
  logic        supported_take;

  logic [NUM_PREGS-1:0]           hw_we;
  logic [NUM_PREGS-1:0][XLEN-1:0] hw_d;
  logic [NUM_PREGS-1:0][XLEN-1:0] regs;

  logic            dcap_en, icap_en;
  logic [XLEN-1:0] status_val, dfmt_val, ifmt_val;
  logic [XLEN-1:0] exc_base, exc_next, vec_pc;

  assign kind           = fault_kind_e'(flt_kind);
  assign flt_ready      = !rdr_valid || rdr_ready;
  assign accept         = flt_valid && flt_ready;
  assign supported_take = accept && !info.unsupported;

  trap_vector_map u_map (
    .kind (kind),
    .info (info)
  );

  trap_fault_capture #(
    .XLEN      (XLEN),
    .PAGE_BITS (PAGE_BITS),
    .INST_W    (INST_W),
    .FLAG_W    (FLAG_W)
  ) u_cap (
    .take       (supported_take),
    .cls        (info.cls),
    .spec       (flt_spec),
    .pte_load   (flt_pte_load),
    .no_fault   (flt_no_fault),
    .pc         (flt_pc),
    .va         (flt_va),
    .inst       (flt_inst),
    .flags      (flt_flags),
    .data_tbase (regs[PR_DPTB]),
    .inst_tbase (regs[PR_IPTB]),
    .dcap_en    (dcap_en),
    .icap_en    (icap_en),
    .status_val (status_val),
    .dfmt_val   (dfmt_val),
    .ifmt_val   (ifmt_val)
  );

  // restart address first, then the skip step on top of it
  assign exc_base = (info.force_restart || !flt_priv) ? flt_pc : regs[PR_EXC];
  assign exc_next = exc_base + (info.skip_inst ? INST_BYTES : '0);
  assign vec_pc   = regs[PR_VBASE] + {{(XLEN-VEC_W){1'b0}}, info.offset};

  always_comb begin
    hw_we = '0;
    hw_d  = '0;
    hw_we[PR_EXC]  = supported_take;
    hw_d[PR_EXC]   = exc_next;
    hw_we[PR_FVA]  = dcap_en;
    hw_d[PR_FVA]   = flt_va;
    hw_we[PR_MMST] = dcap_en;
    hw_d[PR_MMST]  = status_val;
    hw_we[PR_DFVA] = dcap_en;
    hw_d[PR_DFVA]  = dfmt_val;
    hw_we[PR_ITAG] = icap_en;
    hw_d[PR_ITAG]  = flt_pc;
    hw_we[PR_IFVA] = icap_en;
    hw_d[PR_IFVA]  = ifmt_val;
  end

  trap_priv_regs #(
    .XLEN (XLEN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (reg_we),
    .sw_idx   (reg_idx),
    .sw_wdata (reg_wdata),
    .hw_we    (hw_we),
    .hw_d     (hw_d),
    .regs_o   (regs)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_PREGS; i++) begin
      if (reg_idx == PIDX_W'(i)) reg_rdata = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr_valid <= 1'b0;
      rdr_pc    <= '0;
      rdr_npc   <= '0;
      rdr_err   <= 1'b0;
    end else if (accept) begin
      rdr_valid <= 1'b1;
      rdr_err   <= info.unsupported;
      if (info.unsupported) begin
        rdr_pc  <= flt_pc;
        rdr_npc <= flt_pc + INST_BYTES;
      end else begin
        rdr_pc  <= vec_pc;
        rdr_npc <= vec_pc + INST_BYTES;
      end
    end else if (rdr_ready) begin
      rdr_valid <= 1'b0;
    end
  end

  assert_stall_hold_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (rdr_valid && !rdr_ready) |=>
      (rdr_valid && $stable(rdr_pc) && $stable(rdr_npc) && $stable(rdr_err)));

  assert_npc_step_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    rdr_valid |-> (rdr_npc == rdr_pc + INST_BYTES));

  assert_spec_keeps_fva_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (accept && flt_spec) |=> $stable(regs[PR_FVA]));

  assert_spec_keeps_itag_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (accept && flt_spec) |=> ($stable(regs[PR_ITAG]) && $stable(regs[PR_IFVA])));

  assert_arith_keeps_exc_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (accept && (kind == FK_ARITH) && !(reg_we && reg_idx == PR_EXC))
      |=> ($stable(regs[PR_EXC]) && rdr_err));

endmodule

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic        flt_ready;
  logic [3:0]  flt_kind = '0;
  logic [63:0] flt_pc = '0;
  logic [63:0] flt_va = '0;
  logic [31:0] flt_inst = '0;
  logic [5:0]  flt_flags = '0;
  logic        flt_priv = 1'b0;
  logic        flt_spec = 1'b0;
  logic        flt_pte_load = 1'b0;
  logic        flt_no_fault = 1'b0;
  logic        rdr_valid;
  logic        rdr_ready = 1'b1;
  logic [63:0] rdr_pc;
  logic [63:0] rdr_npc;
  logic        rdr_err;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_reg [9];

  always #2.5 clk = ~clk;

  trap_entry_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_kind(flt_kind),
    .flt_pc(flt_pc), .flt_va(flt_va), .flt_inst(flt_inst), .flt_flags(flt_flags),
    .flt_priv(flt_priv), .flt_spec(flt_spec), .flt_pte_load(flt_pte_load),
    .flt_no_fault(flt_no_fault),
    .rdr_valid(rdr_valid), .rdr_ready(rdr_ready), .rdr_pc(rdr_pc),
    .rdr_npc(rdr_npc), .rdr_err(rdr_err),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input int k);
    case (k)
      0: return 16'h0001;  1: return 16'h0101;  2: return 16'h0401;
      3: return 16'h0301;  4: return 16'h0201;  5: return 16'h0281;
      6: return 16'h0381;  7: return 16'h0381;  8: return 16'h0181;
      9: return 16'h0181; 10: return 16'h0081; 11: return 16'h0481;
     12: return 16'h0581; 13: return 16'h2001; 14: return 16'h0501;
      default: return 16'h0501;
    endcase
  endfunction

  function automatic logic [63:0] fmt_va(input logic [63:0] tb, input logic [63:0] a);
    return tb | ({13'b0, a[63:13]} << 3);
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 2: return "R12";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // called in the low phase; ends in the low phase
  task automatic sw_write(input int idx, input logic [63:0] d);
    reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (idx < 4) m_reg[idx] = d;
  endtask

  task automatic read_reg(input int idx, output logic [63:0] v);
    reg_idx = 4'(idx);
    #0.2;
    v = reg_rdata;
  endtask

  task automatic check_all_regs(input string ctx);
    logic [63:0] v;
    for (int i = 0; i < 9; i++) begin
      read_reg(i, v);
      chk(tag_of(i), $sformatf("%s reg%0d", ctx, i), v, m_reg[i]);
    end
  endtask

  // model update per requirements; returns the expected response
  task automatic model(input int k, input logic [63:0] pc, va, input logic [31:0] inst,
                       input logic [5:0] fl, input logic pv, sp, pt, nf,
                       output logic [63:0] epc, output logic eerr);
    if (k == 15) begin
      epc = pc; eerr = 1'b1;
    end else begin
      eerr = 1'b0;
      if (k == 0 || k == 2 || !pv) m_reg[3] = pc;
      if (k == 13 || k == 14) m_reg[3] = m_reg[3] + 64'd4;
      epc = m_reg[0] + {48'b0, vec_of(k)};
      if (k >= 3 && k <= 7 && !sp && !pt && !nf) begin
        m_reg[4] = va;
        m_reg[5] = {47'b0, inst[31:26], inst[25:21], fl};
        m_reg[6] = fmt_va(m_reg[1], va);
      end
      if (k >= 8 && k <= 10 && !sp) begin
        m_reg[7] = pc;
        m_reg[8] = fmt_va(m_reg[2], pc);
      end
    end
  endtask

  task automatic drive_req(input int k, input logic [63:0] pc, va, input logic [31:0] inst,
                           input logic [5:0] fl, input logic pv, sp, pt, nf);
    flt_kind = 4'(k); flt_pc = pc; flt_va = va; flt_inst = inst; flt_flags = fl;
    flt_priv = pv; flt_spec = sp; flt_pte_load = pt; flt_no_fault = nf;
    flt_valid = 1'b1;
  endtask

  task automatic fire(input int k, input logic [63:0] pc, va, input logic [31:0] inst,
                      input logic [5:0] fl, input logic pv, sp, pt, nf);
    logic [63:0] epc;
    logic eerr;
    string ctx;
    ctx = $sformatf("k%0d p%0d s%0d t%0d n%0d", k, pv, sp, pt, nf);
    model(k, pc, va, inst, fl, pv, sp, pt, nf, epc, eerr);
    drive_req(k, pc, va, inst, fl, pv, sp, pt, nf);
    @(negedge clk);
    flt_valid = 1'b0;
    chk("R3", {ctx, " rdr_valid"}, {63'b0, rdr_valid}, 64'd1);
    chk(eerr ? "R10" : "R2", {ctx, " rdr_pc"}, rdr_pc, epc);
    chk(eerr ? "R10" : "R3", {ctx, " rdr_npc"}, rdr_npc, epc + 64'd4);
    chk(eerr ? "R10" : "R3", {ctx, " rdr_err"}, {63'b0, rdr_err}, {63'b0, eerr});
    check_all_regs(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] pca, pcb, hold_pc, epc_a, epc_b;
    logic eerr;
    for (int i = 0; i < 9; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "rdr_valid after reset", {63'b0, rdr_valid}, 64'd0);
    chk("R1", "flt_ready after reset", {63'b0, flt_ready}, 64'd1);
    for (int i = 0; i < 9; i++) begin
      read_reg(i, v);
      chk("R1", $sformatf("reg%0d after reset", i), v, 64'd0);
    end

    // R12 register port behaviour
    sw_write(0, 64'h0000_0000_0080_0000);
    sw_write(5, 64'hDEAD_BEEF_0000_1111);
    read_reg(5, v);
    chk("R12", "write to read-only status ignored", v, 64'd0);
    sw_write(8, 64'h1234);
    read_reg(8, v);
    chk("R12", "write to read-only ifva ignored", v, 64'd0);
    read_reg(12, v);
    chk("R12", "out-of-range index reads zero", v, 64'd0);
    read_reg(0, v);
    chk("R12", "vector base written", v, 64'h0000_0000_0080_0000);

    // sweep: every kind, both modes, every qualifier
    for (int k = 0; k < 16; k++) begin
      sw_write(0, 64'h0000_0000_0040_0000 * 64'(k + 1));
      sw_write(1, 64'h0200_0000_0000_0005 ^ (64'(k) << 40));
      sw_write(2, 64'h0300_0000_0000_0002 ^ (64'(k) << 44));
      for (int p = 0; p < 2; p++) begin
        for (int m = 0; m < 4; m++) begin
          logic [63:0] pc, va;
          logic [31:0] inst;
          logic [5:0]  fl;
          sw_write(3, 64'hEEEE_0000_0000_0000 + 64'(k * 64 + p * 8 + m) * 64'd16);
          pc   = 64'hFFFF_8000_0000_0000 + 64'(k) * 64'h1_0020_2000
                 + 64'(p) * 64'h4000 + 64'(m) * 64'h80;
          va   = 64'h0000_07AB_CDE0_1235 + 64'(k) * 64'h2_0000_6000 + 64'(m) * 64'h3F0;
          inst = {6'(k + 33), 5'(m * 7 + p), 21'h0ABCD};
          fl   = 6'(k * 3 + m + 1);
          fire(k, pc, va, inst, fl, p[0], m == 1, m == 2, m == 3);
        end
      end
    end

    // R11 back-pressure: hold the response, queue a second request
    pca = 64'h0000_4000_0000_1000;
    pcb = 64'h0000_5000_0000_2000;
    sw_write(0, 64'h0000_0000_0100_0000);
    sw_write(3, 64'h0);
    rdr_ready = 1'b0;
    model(1, pca, 64'h0, 32'h0, 6'h0, 1'b0, 1'b0, 1'b0, 1'b0, epc_a, eerr);
    drive_req(1, pca, 64'h0, 32'h0, 6'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    model(13, pcb, 64'h0, 32'h0, 6'h0, 1'b1, 1'b0, 1'b0, 1'b0, epc_b, eerr);
    drive_req(13, pcb, 64'h0, 32'h0, 6'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    #0.2;
    chk("R11", "stall valid", {63'b0, rdr_valid}, 64'd1);
    chk("R11", "stall ready low", {63'b0, flt_ready}, 64'd0);
    chk("R3", "first redirect pc", rdr_pc, epc_a);
    hold_pc = rdr_pc;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R11", "held pc stable", rdr_pc, hold_pc);
      chk("R11", "held ready low", {63'b0, flt_ready}, 64'd0);
      read_reg(3, v);
      chk("R11", "queued request not taken", v, pca);
    end
    rdr_ready = 1'b1;
    #0.2;
    chk("R11", "ready follows rdr_ready", {63'b0, flt_ready}, 64'd1);
    @(negedge clk);
    flt_valid = 1'b0;
    chk("R11", "second response valid", {63'b0, rdr_valid}, 64'd1);
    chk("R11", "second response pc", rdr_pc, epc_b);
    read_reg(3, v);
    chk("R5", "second request taken once", v, pca + 64'd4);
    @(negedge clk);
    chk("R11", "drained", {63'b0, rdr_valid}, 64'd0);
    check_all_regs("after stall");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule